// File: doc/BRIEF.md
# Acquire/Release Cache Walk Controller

This block sits in front of a small L1 data cache and turns memory-ordering requests into maintenance traffic. A request may carry an acquire flag, a release flag and a kernel-scope flag. A release makes the block step through every line index of the cache and send one writeback command per index. An acquire makes it send one invalidate command per index instead. A request with both flags sends a full invalidate pass and then a full writeback pass. Commands leave on a valid/ready port, one per clock at most.

The block counts the writebacks and invalidates that have been sent but not yet finished. It lowers the count for each done pulse from the cache side. While any writeback is outstanding, ordinary issue is held off. Outstanding invalidates never hold it off. A kernel-end request (kernel scope with release) is parked in a small queue together with its context number. It is reported on the completion port only once the writeback count is zero. When the last writeback finishes, the block also raises a one-cycle retry strobe so that stalled requesters try again.

Top module: `acq_rel_walker`

## Requirements
- R1: An accepted release-only request produces exactly LINES commands with cmdOp=1 (writeback), carrying indices 0,1,…,LINES-1 in that order, one per cycle in which cmdValid and cmdReady are both high; while cmdReady is low, cmdIdx and cmdOp hold.
- R2: An accepted acquire-only request produces exactly LINES commands with cmdOp=0 (invalidate), carrying indices 0 to LINES-1 in order.
- R3: An accepted request flagged with both acquire and release, and not kernel scope, produces LINES invalidate commands followed by LINES writeback commands, each pass in index order 0 to LINES-1.
- R4: issueEn is low, and a non-kernel request sees reqReady low, while any writeback is outstanding. issueEn returns high in the cycle after the done pulse of the last outstanding writeback is taken, and retryPulse is high for exactly that one cycle.
- R5: Outstanding invalidates alone keep issueEn high, and a plain request is accepted.
- R6: A kernel-end request (reqKernel=1, reqRel=1) is queued with its reqCtx and starts a writeback walk. kendValid with kendCtx is raised only while no writeback is outstanding and no writeback walk is running. Queued entries come out one per cycle, oldest first.
- R7: While writebacks are outstanding, kernel-scope requests are still accepted. A kernel-scope release is queued and starts no walk. A kernel-scope acquire starts an invalidate walk only if no invalidate is outstanding; otherwise it starts no walk.
- R8: A wbDone pulse while no writeback is outstanding raises errUnderflow in the same cycle, and the writeback count stays at zero. An invDone pulse while no invalidate is outstanding is ignored.
- R9: reqReady is low while a walk is in progress (cmdValid high).
- R10: After reset cmdValid, kendValid, retryPulse and errUnderflow are low, and issueEn and reqReady are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqAcq | input | 1 | Request has acquire semantics |
| reqRel | input | 1 | Request has release semantics |
| reqKernel | input | 1 | Request is kernel scope |
| reqCtx | input | CTX_W | Context number of a kernel-end request |
| reqReady | output | 1 | Request is accepted this cycle |
| cmdValid | output | 1 | Maintenance command present |
| cmdReady | input | 1 | Cache side takes the command |
| cmdOp | output | 1 | 0 = invalidate, 1 = writeback |
| cmdIdx | output | IDX_W | Line index of the command |
| wbDone | input | 1 | One writeback finished |
| invDone | input | 1 | One invalidate finished |
| issueEn | output | 1 | Normal issue allowed (no writeback outstanding) |
| retryPulse | output | 1 | One-cycle strobe when writebacks drain |
| kendValid | output | 1 | Kernel-end completion present |
| kendCtx | output | CTX_W | Context number of the completion |
| errUnderflow | output | 1 | Writeback done with nothing outstanding |

## Verification
On every cycle the assertions check the command hold under back-pressure, that reqReady stays low during a walk, that a writeback command blocks issue, that completions and retry strobes appear only with issue enabled, that an acquire starts its walk at index zero, and that an underflow leaves the count at zero. The full index order of each pass, the invalidate-then-writeback ordering, the exact done pulse that reopens issue, and the oldest-first release of queued kernel ends can only be shown by the bench's scenarios. The same goes for which kernel-scope requests start a walk while writebacks are outstanding.

// File: rtl/fence_walk_pkg.sv
package fence_walk_pkg;
  typedef enum logic [1:0] {
    WALK_IDLE = 2'd0,
    WALK_INV  = 2'd1,
    WALK_WB   = 2'd2
  } walkState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic idxInc;
    logic invInc;
    logic wbInc;
    logic kendPush;
    logic kendPop;
  } dpStrobes_t;

  localparam logic OP_INV = 1'b0;
  localparam logic OP_WB  = 1'b1;
endpackage

// File: rtl/fence_walk_dp.sv
module fence_walk_dp
  import fence_walk_pkg::*;
#(
  parameter int LINES      = 16,
  parameter int CTX_W      = 4,
  parameter int KEND_DEPTH = 4,
  localparam int IDX_W  = (LINES > 1) ? $clog2(LINES) : 1,
  localparam int CNT_W  = $clog2(2 * LINES + 1),
  localparam int PTR_W  = (KEND_DEPTH > 1) ? $clog2(KEND_DEPTH) : 1,
  localparam int OCC_W  = $clog2(KEND_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dpStrobes_t       strobes,
  input  logic [CTX_W-1:0] pushCtx,
  input  logic             wbDone,
  input  logic             invDone,
  output logic [IDX_W-1:0] idx,
  output logic             idxLast,
  output logic             wbZero,
  output logic             invZero,
  output logic             fifoFull,
  output logic             fifoEmpty,
  output logic [CTX_W-1:0] headCtx,
  output logic             underflow,
  output logic             retry
);
  logic [CNT_W-1:0] wbCnt, invCnt;
  logic             wbDec, invDec;
  logic [CTX_W-1:0] kendMem [KEND_DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [OCC_W-1:0] occ;

  assign idxLast   = (idx == IDX_W'(LINES - 1));
  assign wbZero    = (wbCnt == '0);
  assign invZero   = (invCnt == '0);
  assign wbDec     = wbDone && !wbZero;
  assign invDec    = invDone && !invZero;
  assign underflow = wbDone && wbZero;
  assign fifoFull  = (occ == OCC_W'(KEND_DEPTH));
  assign fifoEmpty = (occ == '0);
  assign headCtx   = kendMem[rdPtr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx    <= '0;
      wbCnt  <= '0;
      invCnt <= '0;
      retry  <= 1'b0;
    end else begin
      if (strobes.idxInc) idx <= idxLast ? '0 : idx + 1'b1;
      wbCnt  <= wbCnt + CNT_W'(strobes.wbInc) - CNT_W'(wbDec);
      invCnt <= invCnt + CNT_W'(strobes.invInc) - CNT_W'(invDec);
      retry  <= wbDec && (wbCnt == CNT_W'(1)) && !strobes.wbInc;
    end
  end

  // kernel-end queue
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wrPtr <= '0;
      rdPtr <= '0;
      occ   <= '0;
    end else begin
      if (strobes.kendPush)
        wrPtr <= (wrPtr == PTR_W'(KEND_DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (strobes.kendPop)
        rdPtr <= (rdPtr == PTR_W'(KEND_DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      occ <= occ + OCC_W'(strobes.kendPush) - OCC_W'(strobes.kendPop);
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.kendPush) kendMem[wrPtr] <= pushCtx;
  end
endmodule

// File: rtl/fence_walk_ctrl.sv
module fence_walk_ctrl
  import fence_walk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reqValid,
  input  logic       reqAcq,
  input  logic       reqRel,
  input  logic       reqKernel,
  output logic       reqReady,
  output logic       cmdValid,
  input  logic       cmdReady,
  output logic       cmdOp,
  input  logic       idxLast,
  input  logic       wbZero,
  input  logic       invZero,
  input  logic       fifoFull,
  input  logic       fifoEmpty,
  output logic       kendValid,
  output dpStrobes_t strobes
);
  walkState_e state, stateNext;
  logic       chainWb, chainWbNext;
  logic       idle, kernRel, accept, fire;
  logic       startInv, startWb, chain;

  assign idle     = (state == WALK_IDLE);
  assign kernRel  = reqKernel && reqRel;
  assign reqReady = idle && (wbZero || reqKernel) && !(kernRel && fifoFull);
  assign accept   = reqValid && reqReady;
  assign cmdValid = !idle;
  assign cmdOp    = (state == WALK_WB) ? OP_WB : OP_INV;
  assign fire     = cmdValid && cmdReady;
  assign kendValid = !fifoEmpty && wbZero && (state != WALK_WB);

  always_comb begin
    startInv = 1'b0;
    startWb  = 1'b0;
    chain    = 1'b0;
    if (!wbZero) begin
      startInv = reqKernel && reqAcq && invZero;
    end else if (kernRel) begin
      startWb = 1'b1;
    end else if (reqAcq && reqRel) begin
      startInv = 1'b1;
      chain    = 1'b1;
    end else if (reqRel) begin
      startWb = 1'b1;
    end else if (reqAcq) begin
      startInv = 1'b1;
    end
  end

  always_comb begin
    stateNext   = state;
    chainWbNext = chainWb;
    unique case (state)
      WALK_IDLE: if (accept) begin
        if (startWb) stateNext = WALK_WB;
        else if (startInv) begin
          stateNext   = WALK_INV;
          chainWbNext = chain;
        end
      end
      WALK_INV: if (fire && idxLast) begin
        stateNext   = chainWb ? WALK_WB : WALK_IDLE;
        chainWbNext = 1'b0;
      end
      WALK_WB: if (fire && idxLast) stateNext = WALK_IDLE;
      default: stateNext = WALK_IDLE;
    endcase
  end

  always_comb begin
    strobes.idxInc   = fire;
    strobes.invInc   = fire && (state == WALK_INV);
    strobes.wbInc    = fire && (state == WALK_WB);
    strobes.kendPush = accept && kernRel;
    strobes.kendPop  = kendValid;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= WALK_IDLE;
      chainWb <= 1'b0;
    end else begin
      state   <= stateNext;
      chainWb <= chainWbNext;
    end
  end
endmodule

// File: rtl/acq_rel_walker.sv
module acq_rel_walker
  import fence_walk_pkg::*;
#(
  parameter int LINES      = 16,
  parameter int CTX_W      = 4,
  parameter int KEND_DEPTH = 4,
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reqValid,
  input  logic             reqAcq,
  input  logic             reqRel,
  input  logic             reqKernel,
  input  logic [CTX_W-1:0] reqCtx,
  output logic             reqReady,
  output logic             cmdValid,
  input  logic             cmdReady,
  output logic             cmdOp,
  output logic [IDX_W-1:0] cmdIdx,
  input  logic             wbDone,
  input  logic             invDone,
  output logic             issueEn,
  output logic             retryPulse,
  output logic             kendValid,
  output logic [CTX_W-1:0] kendCtx,
  output logic             errUnderflow
);
  dpStrobes_t strobes;
  logic idxLast, wbZero, invZero, fifoFull, fifoEmpty;

  fence_walk_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_n),
    .reqValid(reqValid), .reqAcq(reqAcq), .reqRel(reqRel), .reqKernel(reqKernel),
    .reqReady(reqReady), .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdOp(cmdOp),
    .idxLast(idxLast), .wbZero(wbZero), .invZero(invZero),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty),
    .kendValid(kendValid), .strobes(strobes)
  );

  fence_walk_dp #(.LINES(LINES), .CTX_W(CTX_W), .KEND_DEPTH(KEND_DEPTH)) i_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .pushCtx(reqCtx),
    .wbDone(wbDone), .invDone(invDone),
    .idx(cmdIdx), .idxLast(idxLast), .wbZero(wbZero), .invZero(invZero),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty), .headCtx(kendCtx),
    .underflow(errUnderflow), .retry(retryPulse)
  );

  assign issueEn = wbZero;
endmodule

// File: rtl/fence_walk_chk.sv
module fence_walk_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reqValid,
  input logic             reqAcq,
  input logic             reqRel,
  input logic             reqReady,
  input logic             cmdValid,
  input logic             cmdReady,
  input logic             cmdOp,
  input logic [IDX_W-1:0] cmdIdx,
  input logic             issueEn,
  input logic             retryPulse,
  input logic             kendValid,
  input logic             errUnderflow
);
  // R1
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmdValid && !cmdReady |=> cmdValid && $stable(cmdIdx) && $stable(cmdOp));

  // R2
  acq_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid && reqReady && reqAcq && !reqRel && issueEn |=> cmdValid && !cmdOp && (cmdIdx == '0));

  // R4
  wb_blocks_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmdValid && cmdReady && cmdOp |=> !issueEn);

  // R4
  retry_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retryPulse |-> issueEn);

  // R6
  kend_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kendValid |-> issueEn);

  // R8
  underflow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    errUnderflow && !(cmdValid && cmdReady && cmdOp) |=> issueEn);

  // R9
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmdValid |-> !reqReady);
endmodule

bind acq_rel_walker fence_walk_chk #(.IDX_W(IDX_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqAcq(reqAcq), .reqRel(reqRel),
  .reqReady(reqReady), .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdOp(cmdOp),
  .cmdIdx(cmdIdx), .issueEn(issueEn), .retryPulse(retryPulse),
  .kendValid(kendValid), .errUnderflow(errUnderflow)
);

// File: tb/test_acq_rel_walker.sv
module test_acq_rel_walker;
  localparam int LINES = 16;
  localparam int CTX_W = 4;
  localparam int IDX_W = $clog2(LINES);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reqValid = 0, reqAcq = 0, reqRel = 0, reqKernel = 0;
  logic [CTX_W-1:0] reqCtx = '0;
  logic reqReady, cmdValid, cmdOp, issueEn, retryPulse, kendValid, errUnderflow;
  logic cmdReady = 0, wbDone = 0, invDone = 0;
  logic [IDX_W-1:0] cmdIdx;
  logic [CTX_W-1:0] kendCtx;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  acq_rel_walker #(.LINES(LINES), .CTX_W(CTX_W), .KEND_DEPTH(4)) i_acq_rel_walker (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqAcq(reqAcq), .reqRel(reqRel),
    .reqKernel(reqKernel), .reqCtx(reqCtx), .reqReady(reqReady),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdOp(cmdOp), .cmdIdx(cmdIdx),
    .wbDone(wbDone), .invDone(invDone), .issueEn(issueEn), .retryPulse(retryPulse),
    .kendValid(kendValid), .kendCtx(kendCtx), .errUnderflow(errUnderflow)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // starts and ends at a negedge
  task automatic sendReq(input bit acq, input bit rel, input bit ker, input int ctx,
                         input bit expReady, input string req);
    reqValid = 1; reqAcq = acq; reqRel = rel; reqKernel = ker; reqCtx = CTX_W'(ctx);
    #1;
    chk(req, reqReady, expReady);
    @(posedge clk); @(negedge clk);
    reqValid = 0; reqAcq = 0; reqRel = 0; reqKernel = 0;
  endtask

  task automatic runWalk(input int nInv, input int nWb, input string req);
    int got = 0;
    int guard = 0;
    while (got < nInv + nWb && guard < 400) begin
      cmdReady = ((guard % 3) != 2);
      #1;
      if (cmdValid && cmdReady) begin
        chk(req, cmdOp, (got < nInv) ? 0 : 1);
        chk(req, cmdIdx, got % LINES);
        got++;
      end
      @(posedge clk); @(negedge clk);
      guard++;
    end
    cmdReady = 0;
    chk(req, got, nInv + nWb);
    #1;
    chk(req, cmdValid, 0);
  endtask

  task automatic pulseWb(input int n);
    repeat (n) begin
      wbDone = 1; @(posedge clk); @(negedge clk); wbDone = 0;
    end
  endtask

  task automatic pulseInv(input int n);
    repeat (n) begin
      invDone = 1; @(posedge clk); @(negedge clk); invDone = 0;
    end
  endtask

  task automatic idleCycles(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    // R10 reset state
    chk("R10 cmdValid", cmdValid, 0);
    chk("R10 kendValid", kendValid, 0);
    chk("R10 retryPulse", retryPulse, 0);
    chk("R10 errUnderflow", errUnderflow, 0);
    chk("R10 issueEn", issueEn, 1);
    chk("R10 reqReady", reqReady, 1);

    // R8 underflow at zero
    wbDone = 1; invDone = 1; #1;
    chk("R8 errUnderflow", errUnderflow, 1);
    @(posedge clk); @(negedge clk);
    wbDone = 0; invDone = 0; #1;
    chk("R8 count stays zero", issueEn, 1);
    chk("R8 no error after", errUnderflow, 0);

    // R1 release walk
    sendReq(0, 1, 0, 0, 1, "R1 accept");
    runWalk(0, LINES, "R1 wb walk");
    chk("R4 issue blocked", issueEn, 0);
    sendReq(0, 0, 0, 0, 0, "R4 plain stalled");
    pulseWb(LINES - 1);
    #1;
    chk("R4 still blocked", issueEn, 0);
    chk("R4 no retry yet", retryPulse, 0);
    pulseWb(1);
    #1;
    chk("R4 issue reopened", issueEn, 1);
    chk("R4 retry pulse", retryPulse, 1);
    idleCycles(1); #1;
    chk("R4 retry one cycle", retryPulse, 0);

    // R2 acquire walk, R5 invalidates do not block
    sendReq(1, 0, 0, 0, 1, "R2 accept");
    #1;
    chk("R9 ready low in walk", reqReady, 0);
    runWalk(LINES, 0, "R2 inv walk");
    chk("R5 issue open", issueEn, 1);
    sendReq(0, 0, 0, 0, 1, "R5 plain accepted");
    pulseInv(LINES);
    pulseInv(1); // R8 extra invalidate done ignored
    #1;
    chk("R8 inv extra no error", errUnderflow, 0);

    // R3 acquire plus release
    sendReq(1, 1, 0, 0, 1, "R3 accept");
    runWalk(LINES, LINES, "R3 inv then wb");
    chk("R3 issue blocked", issueEn, 0);
    pulseWb(LINES); pulseInv(LINES);
    #1;
    chk("R3 drained", issueEn, 1);

    // R6 kernel end, R7 kernel requests while wb outstanding
    sendReq(0, 1, 1, 5, 1, "R6 kernel end accept");
    #1;
    chk("R6 no completion in walk", kendValid, 0);
    runWalk(0, LINES, "R6 wb walk");
    chk("R6 held while outstanding", kendValid, 0);
    sendReq(0, 1, 1, 6, 1, "R7 kernel rel accepted");
    idleCycles(2); #1;
    chk("R7 kernel rel no walk", cmdValid, 0);
    sendReq(1, 0, 1, 0, 1, "R7 kernel acq accepted");
    runWalk(LINES, 0, "R7 inv walk");
    sendReq(1, 0, 1, 0, 1, "R7 second kernel acq accepted");
    idleCycles(2); #1;
    chk("R7 no walk with inv outstanding", cmdValid, 0);
    sendReq(0, 0, 0, 0, 0, "R4 plain stalled again");
    pulseWb(LINES - 1);
    #1;
    chk("R6 still held", kendValid, 0);
    pulseWb(1);
    #1;
    chk("R6 first completion", kendValid, 1);
    chk("R6 first ctx", kendCtx, 5);
    idleCycles(1); #1;
    chk("R6 second completion", kendValid, 1);
    chk("R6 second ctx", kendCtx, 6);
    idleCycles(1); #1;
    chk("R6 queue empty", kendValid, 0);
    pulseInv(LINES);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule